// File: doc/BRIEF.md
# Slave Parallel Configuration Loader

This block is the receiving end of a parallel configuration port that an outside agent starts. The clock comes from outside the block, and the block never produces one. After a start pulse, the block takes one parallel word on each rising edge of that clock. A mode input sets whether the word is a full 16-bit word or a single byte. Each word goes to a configuration-memory write interface as a one-cycle write strobe, together with the address of the word and the word itself.

The block also drives an address up counter. This lets a plain external memory that holds the bitstream, and has no address logic of its own, be read in order: the memory's data output connects straight back to the data input. The counter returns to zero at each start and steps by one after each word taken. If it passes its top value, it rolls over to zero and raises an overflow flag that stays set. A stop input ends loading, and the address then stays where it is.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset, the port is idle: address 0, busy low, overflow low, write strobe low, write address 0 and write data 0. Busy rises only on the clock edge that follows an edge at which start was sampled high.
- R2: An edge at which start is high returns the address to 0, clears the overflow flag and sets busy, with no write strobe. Start takes priority over stop and also restarts a load that is already running.
- R3: While busy, an edge with both start and stop low takes one word. On the next cycle the write strobe is high for that one cycle, the write address equals the address that was driven before the edge, and the address is one greater.
- R4: In wide mode (mode input 1), the write data is data input bits 15:0. In narrow mode (mode input 0), the write data is data input bits 7:0, and bits 15:8 of the write data are 0.
- R5: While busy, an edge with stop high and start low ends loading. Busy falls, no word is taken, and the address keeps its value.
- R6: While idle and without start, the data, mode and stop inputs have no effect: the address holds and the write strobe stays low.
- R7: When a word is taken at the all-ones address, the address rolls over to 0 and the overflow flag is set. The flag stays set until the next start.
- R8: The address output is ADDR_W bits wide, 20 by default, and counts up in steps of one only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock, supplied from outside; data is captured on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to cfg_clk |
| start_i | input | 1 | Starts or restarts loading |
| stop_i | input | 1 | Ends loading |
| wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words on bits 7:0 |
| data_i | input | DATA_W (16) | Parallel word read from the external memory |
| addr_o | output | ADDR_W (20) | Address to the external memory |
| busy_o | output | 1 | Loading is in progress |
| ovf_o | output | 1 | Sticky flag: the address rolled over |
| wr_en_o | output | 1 | One-cycle write strobe to configuration memory |
| wr_addr_o | output | ADDR_W (20) | Address of the word being written |
| wr_data_o | output | DATA_W (16) | Word being written, zero-filled in byte mode |

## Verification
A wrong count or a wrong load state shows at the ports one cycle later. It appears either as an address that does not follow 0, 1, 2 and so on, or as a write whose data does not match the external memory contents at its write address. The bench models the external memory and the port behaviourally and compares every output on every cycle, so the first bad edge is reported at once. A small address width is used so that rollover and the sticky overflow flag are reached within a short run.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ovf_o
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ovf;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr_i) begin
            ctr_d.addr = '0;
            ctr_d.ovf  = 1'b0;
        end else if (inc_i) begin
            if (ctr_q.addr == TOP) begin
                ctr_d.addr = '0;
                ctr_d.ovf  = 1'b1;
            end else begin
                ctr_d.addr = ctr_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign addr_o = ctr_q.addr;
    assign ovf_o  = ctr_q.ovf;
endmodule

// File: rtl/cfg_word_fmt.sv
module cfg_word_fmt #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              wide_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o
);
    generate
        if (DATA_W > NARROW_W) begin : g_two_widths
            always_comb begin
                if (wide_i) word_o = data_i;
                else        word_o = {{(DATA_W-NARROW_W){1'b0}}, data_i[NARROW_W-1:0]};
            end
        end else begin : g_one_width
            logic unused_mode;
            assign unused_mode = wide_i;
            assign word_o      = data_i;
        end
    endgenerate
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              ovf_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    typedef struct packed {
        ld_state_e         state;
        logic              we;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              take_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] fmt_word;

    cfg_word_fmt #(
        .DATA_W   (DATA_W),
        .NARROW_W (BYTE_W)
    ) u_fmt (
        .wide_i (wide_i),
        .data_i (data_i),
        .word_o (fmt_word)
    );

    cfg_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_ctr (
        .clk    (cfg_clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .inc_i  (take_d),
        .addr_o (cur_addr),
        .ovf_o  (ovf_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.we = 1'b0;
        take_d   = (ctl_q.state == LD_RUN) && !start_i && !stop_i;
        if (start_i) begin
            ctl_d.state = LD_RUN;
        end else if ((ctl_q.state == LD_RUN) && stop_i) begin
            ctl_d.state = LD_IDLE;
        end
        if (take_d) begin
            ctl_d.we = 1'b1;
            ctl_d.wa = cur_addr;
            ctl_d.wd = fmt_word;
        end
    end

    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            ctl_q.state <= LD_IDLE;
            ctl_q.we    <= 1'b0;
            ctl_q.wa    <= '0;
            ctl_q.wd    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr_o    = cur_addr;
    assign busy_o    = (ctl_q.state == LD_RUN);
    assign wr_en_o   = ctl_q.we;
    assign wr_addr_o = ctl_q.wa;
    assign wr_data_o = ctl_q.wd;
endmodule

// File: rtl/cfg_par_loader_chk.sv
module cfg_par_loader_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input logic              cfg_clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              wide_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              ovf_o,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o
);
    // R1
    busy_rise_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R2
    start_clear_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        start_i |=> (addr_o == '0) && busy_o && !ovf_o && !wr_en_o);

    // R3
    take_word_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (busy_o && !start_i && !stop_i && (addr_o != {ADDR_W{1'b1}}))
        |=> wr_en_o && (wr_addr_o == $past(addr_o)) && (addr_o == $past(addr_o) + 1'b1));

    // R4
    narrow_zero_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (busy_o && !start_i && !stop_i && !wide_i) |=> (wr_data_o[DATA_W-1:8] == '0));

    // R5
    stop_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (busy_o && stop_i && !start_i) |=> !busy_o && !wr_en_o && $stable(addr_o));

    // R6
    idle_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !wr_en_o && $stable(addr_o));

    // R7
    wrap_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (busy_o && !start_i && !stop_i && (addr_o == {ADDR_W{1'b1}})) |=> (addr_o == '0) && ovf_o);

    // R7
    ovf_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (ovf_o && !start_i) |=> ovf_o);

    // R8
    addr_step_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!start_i) |=> (addr_o == $past(addr_o)) || (addr_o == $past(addr_o) + 1'b1));
endmodule

bind cfg_par_loader cfg_par_loader_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wide_i    (wide_i),
    .addr_o    (addr_o),
    .busy_o    (busy_o),
    .ovf_o     (ovf_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
);

// File: tb/sim_cfg_par_loader.sv
`timescale 1ns/1ps
module sim_cfg_par_loader;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, stop = 1'b0, wide = 1'b1;
    logic [DW-1:0] data;
    logic [AW-1:0] addr, wa;
    logic          busy, ovf, we;
    logic [DW-1:0] wd;

    logic [DW-1:0] mem [DEPTH];
    int checks = 0, errors = 0;
    bit done = 0;

    // expected state
    int m_addr, m_wa, m_wd;
    bit m_busy, m_ovf, m_we;

    always #2 clk = ~clk;

    assign data = mem[addr];

    cfg_par_loader #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .cfg_clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .wide_i(wide), .data_i(data), .addr_o(addr), .busy_o(busy),
        .ovf_o(ovf), .wr_en_o(we), .wr_addr_o(wa), .wr_data_o(wd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_busy = 0; m_ovf = 0; m_we = 0; m_wa = 0; m_wd = 0;
        end else begin
            m_we = 0;
            if (start) begin
                m_busy = 1; m_addr = 0; m_ovf = 0;
            end else if (m_busy && stop) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_we = 1;
                m_wa = m_addr;
                m_wd = wide ? int'(mem[m_addr]) : int'(mem[m_addr]) & 'hff;
                if (m_addr == DEPTH - 1) begin
                    m_addr = 0; m_ovf = 1;
                end else begin
                    m_addr = m_addr + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(addr) == m_addr, "R3/R8 addr", int'(addr), m_addr);
            chk(busy == m_busy, "R1/R5 busy", busy, m_busy);
            chk(ovf == m_ovf, "R7 ovf", ovf, m_ovf);
            chk(we == m_we, "R6 wr_en", we, m_we);
            if (m_we) begin
                chk(int'(wa) == m_wa, "R3 wr_addr", int'(wa), m_wa);
                chk(int'(wd) == m_wd, "R4 wr_data", int'(wd), m_wd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'((i * 16'h3b1) ^ 16'ha55a);
        step(3);
        // R1 reset state
        chk(addr == 0 && !busy && !ovf && !we && wa == 0 && wd == 0, "R1 reset", int'(addr), 0);
        rst_n = 1'b1;
        // R6 idle inputs ignored
        stop = 1'b1; wide = 1'b0; step(4); stop = 1'b0; step(2);
        // R2 R3 R4 wide load
        wide = 1'b1; start = 1'b1; step(1); start = 1'b0; step(10);
        // R5 stop, then hold
        stop = 1'b1; step(1); stop = 1'b0; step(4);
        // R4 narrow load through rollover (R7)
        wide = 1'b0; start = 1'b1; step(1); start = 1'b0; step(DEPTH + 6);
        // R7 flag stays while stopped
        stop = 1'b1; step(3); stop = 1'b0; step(2);
        // R2 start clears flag; start beats stop
        start = 1'b1; stop = 1'b1; step(1); start = 1'b0; stop = 1'b0; step(5);
        // R2 restart during load, mixed widths
        start = 1'b1; step(1); start = 1'b0; wide = 1'b1; step(3); wide = 1'b0; step(3);
        stop = 1'b1; step(1); stop = 1'b0; step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule